// File: doc/BRIEF.md
# Compact Compare/PWM Timer

This block is a small general-purpose timer built around a 10-bit up-counter and two match comparators. The period comparator holds a 3-bit value and looks only at the counter's three most significant bits, so it produces periods in steps of 128 counts. The duty comparator holds a full 10-bit value and matches the whole counter. A mode field chooses the function: compare-match output, PWM output, or plain timing with no pin activity.

Software sets the timer up through a small write-only register bus with four addresses. The counter advances on a tick chosen from seven sources: the system clock, a built-in divide-by-four of it, three enable strobes supplied from outside, and either edge of an external clock pin after synchronisation. A run bit starts and stops the timer, and a pause bit freezes it. The output pin supports four match actions, an initial or active level, and an inversion bit. Two single-cycle event outputs report period and duty matches to an interrupt controller outside the block.

Top module: `pwm_cmp_timer`

## Requirements
- R1: During and after a synchronous reset, every control field is zero, `count_o` is 0, and `pin_o`, `p_irq_o` and `a_irq_o` are low.
- R2: The tick source is set by the 3-bit `csel` field in control word 0, bits 4:2. The codes are: 000 every fourth clock of a free-running prescaler that starts at reset; 001 every clock; 010 `fh16_en_i`; 011 `fh64_en_i`; 100 and 101 `fsub_en_i`; 110 a rising edge on `ext_clk_i`; 111 a falling edge on `ext_clk_i`. A pin level sampled at clock edge k counts at edge k+2.
- R3: While the run bit (word 0, bit 0) is clear, the counter is reset to 0 on every clock and the pin shows its initial level. While the run bit is set and the pause bit (word 0, bit 1) is set, the count holds its value. Counting resumes when pause is cleared.
- R4: With clear-select (word 1, bit 7) at 0 and the block outside PWM mode, a tick that would make the counter equal the period value P (word 0, bits 7:5) followed by seven zero bits clears it to 0 instead. With P = 0 this is the natural wrap from 1023 to 0.
- R5: With clear-select at 1 and the block outside PWM mode, a tick that would make the counter equal the 10-bit duty value A clears it to 0 instead. With A = 0 no match occurs and the counter wraps at 1023.
- R6: `p_irq_o` and `a_irq_o` are one-cycle pulses that rise together with the clear or advance caused by the matching tick. `a_irq_o` never pulses while A = 0. `p_irq_o` is suppressed in compare mode when clear-select is 1.
- R7: In compare mode (mode field word 1, bits 1:0 = 00), a duty match applies the action field (word 1, bits 3:2): 00 keep, 01 drive low, 10 drive high, 11 toggle. The pin then shows that state XOR the invert bit.
- R8: In PWM mode (mode 10), the swap bit (word 1, bit 6) chooses the period and duty sources. With swap = 0, P sets the period clear and A sets the duty. With swap = 1, A sets the period clear and P×128 sets the duty. The pin is at its active level while the count is below the duty value.
- R9: The initial-level bit (word 1, bit 4) is the stopped level and the PWM active level. The invert bit (word 1, bit 5) inverts the pin in compare and PWM modes. In timer mode (11) and in the reserved mode (01), the pin equals the initial-level bit and is not inverted.
- R10: A write to address 2 only loads an 8-bit holding byte. A write to address 3 commits A as its data bits 1:0 over the held byte. A does not change at any other time.
- R11: Address 0 holds run, pause, csel and P. Address 1 holds mode, action, initial level, invert, swap and clear-select, at the bit positions named above. A new value takes effect on the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (system clock) |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 ctrl0, 1 ctrl1, 2 A low, 3 A high) |
| bus_wdata | input | 8 | Register write data |
| fh16_en_i | input | 1 | External tick enable, fast clock divided by 16 |
| fh64_en_i | input | 1 | External tick enable, fast clock divided by 64 |
| fsub_en_i | input | 1 | External tick enable, slow clock |
| ext_clk_i | input | 1 | Asynchronous external clock pin |
| count_o | output | 10 | Current counter value |
| pin_o | output | 1 | Timer output pin level |
| p_irq_o | output | 1 | Period match event pulse |
| a_irq_o | output | 1 | Duty match event pulse |

## Verification
A register write is seen by the counter on the next clock edge. A match tick clears the counter, pulses the event outputs and changes the compare-mode pin state all on the same edge. The PWM level follows the registered count with no further delay. An external pin edge reaches the counter two edges after it is sampled. The bench keeps a behavioural model that applies these latencies on each rising edge. It compares count, pin and both event outputs against the model at every falling edge, away from the edge the design uses. A few directed checks confirm the absolute values: the reset state, zero count on a period event, the held A before commit, and the missing period events.

// File: rtl/ctim_pkg.sv
package ctim_pkg;
  typedef enum logic [1:0] {
    MODE_CMP = 2'b00,
    MODE_RSV = 2'b01,
    MODE_PWM = 2'b10,
    MODE_TMR = 2'b11
  } tmode_e;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } pact_e;

  localparam logic [1:0] ADR_CTL0 = 2'd0;
  localparam logic [1:0] ADR_CTL1 = 2'd1;
  localparam logic [1:0] ADR_ALO  = 2'd2;
  localparam logic [1:0] ADR_AHI  = 2'd3;

  localparam logic [2:0] CSEL_EXT_RISE = 3'b110;
endpackage

// File: rtl/ctim_regs.sv
module ctim_regs
  import ctim_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PER_W = 3,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic             run_o,
  output logic             pause_o,
  output logic [2:0]       csel_o,
  output logic [PER_W-1:0] per_o,
  output tmode_e           mode_o,
  output pact_e            act_o,
  output logic             init_o,
  output logic             inv_o,
  output logic             swap_o,
  output logic             clrsel_o,
  output logic [CNT_W-1:0] cmpa_o
);
  localparam int HI_W    = CNT_W - DW;
  localparam int PER_LSB = 5;

  logic [DW-1:0] lo_hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o     <= 1'b0;
      pause_o   <= 1'b0;
      csel_o    <= '0;
      per_o     <= '0;
      mode_o    <= MODE_CMP;
      act_o     <= ACT_KEEP;
      init_o    <= 1'b0;
      inv_o     <= 1'b0;
      swap_o    <= 1'b0;
      clrsel_o  <= 1'b0;
      cmpa_o    <= '0;
      lo_hold_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTL0: begin
          run_o   <= wr_data[0];
          pause_o <= wr_data[1];
          csel_o  <= wr_data[4:2];
          per_o   <= wr_data[PER_LSB +: PER_W];
        end
        ADR_CTL1: begin
          mode_o   <= tmode_e'(wr_data[1:0]);
          act_o    <= pact_e'(wr_data[3:2]);
          init_o   <= wr_data[4];
          inv_o    <= wr_data[5];
          swap_o   <= wr_data[6];
          clrsel_o <= wr_data[7];
        end
        ADR_ALO: lo_hold_q <= wr_data;
        default: cmpa_o <= {wr_data[HI_W-1:0], lo_hold_q};
      endcase
    end
  end

  // R10
  a_commit_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == ADR_AHI) |=> $stable(cmpa_o));
endmodule

// File: rtl/ctim_tick_sel.sv
module ctim_tick_sel
  import ctim_pkg::*;
#(
  parameter int PRE_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] csel_i,
  input  logic       run_i,
  input  logic       pause_i,
  input  logic       fh16_en_i,
  input  logic       fh64_en_i,
  input  logic       fsub_en_i,
  input  logic       ext_clk_i,
  output logic       tick_o
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic               div_en;
  logic [SYNC_STAGES:0] ext_sh;
  logic               ext_rise, ext_fall;
  logic               src_en;

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst)                              pre_q <= '0;
        else if (pre_q == PRE_W'(PRE_DIV - 1)) pre_q <= '0;
        else                                  pre_q <= pre_q + 1'b1;
      end
      assign div_en = (pre_q == PRE_W'(PRE_DIV - 1));
    end else begin : g_nopre
      assign div_en = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ext_sh <= '0;
    else     ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign ext_rise = ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES];
  assign ext_fall = ~ext_sh[SYNC_STAGES-1] & ext_sh[SYNC_STAGES];

  always_comb begin
    case (csel_i)
      3'b000:  src_en = div_en;
      3'b001:  src_en = 1'b1;
      3'b010:  src_en = fh16_en_i;
      3'b011:  src_en = fh64_en_i;
      3'b100,
      3'b101:  src_en = fsub_en_i;
      3'b110:  src_en = ext_rise;
      default: src_en = ext_fall;
    endcase
  end

  assign tick_o = run_i & ~pause_i & src_en;

  // R2
  ext_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    (csel_i == CSEL_EXT_RISE && tick_o) |-> $past(ext_clk_i, 2));
endmodule

// File: rtl/ctim_counter.sv
module ctim_counter
  import ctim_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  tmode_e           mode_i,
  input  logic             swap_i,
  input  logic             clrsel_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [CNT_W-1:0] cmpa_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             p_flag_o,
  output logic             a_flag_o,
  output logic             a_strobe_o
);
  localparam int LOW_W = CNT_W - PER_W;

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             p_hit, a_hit, clr_on_a, p_quiet, clr_now;
  logic             p_flag_q, a_flag_q;

  assign cnt_inc  = cnt_q + 1'b1;
  assign p_hit    = (cnt_inc == {per_i, {LOW_W{1'b0}}});
  assign a_hit    = (cmpa_i != '0) && (cnt_inc == cmpa_i);
  assign clr_on_a = (mode_i == MODE_PWM) ? swap_i : clrsel_i;
  assign p_quiet  = (mode_i == MODE_CMP) && clrsel_i;
  assign clr_now  = clr_on_a ? a_hit : p_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      p_flag_q <= 1'b0;
      a_flag_q <= 1'b0;
    end else begin
      p_flag_q <= 1'b0;
      a_flag_q <= 1'b0;
      if (!run_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        cnt_q    <= clr_now ? '0 : cnt_inc;
        p_flag_q <= p_hit && !p_quiet;
        a_flag_q <= a_hit;
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign p_flag_o   = p_flag_q;
  assign a_flag_o   = a_flag_q;
  assign a_strobe_o = tick_i && run_i && a_hit;

  // R3
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0));

  // R3
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && !tick_i) |=> $stable(cnt_q));

  // R6
  a_flag_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    a_flag_q |-> $past(cmpa_i != '0));

  // R6
  p_flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_CMP && clrsel_i && $stable(mode_i) && $stable(clrsel_i)) |-> !p_flag_q);
endmodule

// File: rtl/ctim_outstage.sv
module ctim_outstage
  import ctim_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  tmode_e           mode_i,
  input  pact_e            act_i,
  input  logic             init_i,
  input  logic             inv_i,
  input  logic             swap_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [CNT_W-1:0] cmpa_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             a_strobe_i,
  output logic             pin_o
);
  localparam int LOW_W = CNT_W - PER_W;

  logic             out_q;
  logic [CNT_W-1:0] duty;
  logic             pwm_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
    end else if (!run_i) begin
      out_q <= init_i;
    end else if (a_strobe_i && mode_i == MODE_CMP) begin
      case (act_i)
        ACT_LOW:  out_q <= 1'b0;
        ACT_HIGH: out_q <= 1'b1;
        ACT_FLIP: out_q <= ~out_q;
        default:  out_q <= out_q;
      endcase
    end
  end

  assign duty   = swap_i ? {per_i, {LOW_W{1'b0}}} : cmpa_i;
  assign pwm_on = (cnt_i < duty);

  always_comb begin
    case (mode_i)
      MODE_CMP: pin_o = (run_i ? out_q : init_i) ^ inv_i;
      MODE_PWM: pin_o = (run_i ? (pwm_on ? init_i : ~init_i) : init_i) ^ inv_i;
      default:  pin_o = init_i;
    endcase
  end

  // R7
  flip_action_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_CMP && a_strobe_i && act_i == ACT_FLIP) |=> (out_q != $past(out_q)));
endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
  import ctim_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int PER_W       = 3,
  parameter int DW          = 8,
  parameter int PRE_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr_en,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             fh16_en_i,
  input  logic             fh64_en_i,
  input  logic             fsub_en_i,
  input  logic             ext_clk_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pin_o,
  output logic             p_irq_o,
  output logic             a_irq_o
);
  logic             run, pause, init_lv, inv, swap, clrsel, tick, a_strobe;
  logic [2:0]       csel;
  logic [PER_W-1:0] per;
  logic [CNT_W-1:0] cmpa, cnt;
  tmode_e           mode;
  pact_e            act;

  ctim_regs #(.CNT_W(CNT_W), .PER_W(PER_W), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .run_o(run), .pause_o(pause), .csel_o(csel), .per_o(per), .mode_o(mode),
    .act_o(act), .init_o(init_lv), .inv_o(inv), .swap_o(swap), .clrsel_o(clrsel),
    .cmpa_o(cmpa)
  );

  ctim_tick_sel #(.PRE_DIV(PRE_DIV), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .csel_i(csel), .run_i(run), .pause_i(pause),
    .fh16_en_i(fh16_en_i), .fh64_en_i(fh64_en_i), .fsub_en_i(fsub_en_i),
    .ext_clk_i(ext_clk_i), .tick_o(tick)
  );

  ctim_counter #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .run_i(run), .mode_i(mode), .swap_i(swap),
    .clrsel_i(clrsel), .per_i(per), .cmpa_i(cmpa), .cnt_o(cnt),
    .p_flag_o(p_irq_o), .a_flag_o(a_irq_o), .a_strobe_o(a_strobe)
  );

  ctim_outstage #(.CNT_W(CNT_W), .PER_W(PER_W)) u_out (
    .clk(clk), .rst(rst), .run_i(run), .mode_i(mode), .act_i(act), .init_i(init_lv),
    .inv_i(inv), .swap_i(swap), .per_i(per), .cmpa_i(cmpa), .cnt_i(cnt),
    .a_strobe_i(a_strobe), .pin_o(pin_o)
  );

  assign count_o = cnt;
endmodule

// File: tb/test_pwm_cmp_timer.sv
module test_pwm_cmp_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr_en = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic       fh16_en_i = 1'b0, fh64_en_i = 1'b0, fsub_en_i = 1'b0, ext_clk_i = 1'b0;
  logic [9:0] count_o;
  logic       pin_o, p_irq_o, a_irq_o;

  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;

  pwm_cmp_timer i_pwm_cmp_timer (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .fh16_en_i(fh16_en_i), .fh64_en_i(fh64_en_i), .fsub_en_i(fsub_en_i), .ext_clk_i(ext_clk_i),
    .count_o(count_o), .pin_o(pin_o), .p_irq_o(p_irq_o), .a_irq_o(a_irq_o)
  );

  always #5 clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_A, m_lo, m_P, m_csel, m_mode, m_act, m_pre;
  bit m_run, m_pause, m_init, m_inv, m_swap, m_clr, m_out, m_fp, m_fa, s1, s2, s3;

  always @(posedge clk) begin
    bit en, tk, ph, ah, clra;
    int nx;
    if (rst) begin
      m_cnt = 0; m_A = 0; m_lo = 0; m_P = 0; m_csel = 0; m_mode = 0; m_act = 0; m_pre = 0;
      m_run = 0; m_pause = 0; m_init = 0; m_inv = 0; m_swap = 0; m_clr = 0; m_out = 0;
      m_fp = 0; m_fa = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      case (m_csel)
        0: en = (m_pre == 3);
        1: en = 1;
        2: en = fh16_en_i;
        3: en = fh64_en_i;
        4, 5: en = fsub_en_i;
        6: en = s2 && !s3;
        default: en = !s2 && s3;
      endcase
      tk = m_run && !m_pause && en;
      m_fp = 0; m_fa = 0;
      if (!m_run) begin
        m_cnt = 0;
        m_out = m_init;
      end else if (tk) begin
        nx = (m_cnt + 1) % 1024;
        ph = (nx == m_P * 128);
        ah = (m_A != 0) && (nx == m_A);
        clra = (m_mode == 2) ? m_swap : m_clr;
        if (m_mode == 0 && ah) begin
          if (m_act == 1) m_out = 0;
          else if (m_act == 2) m_out = 1;
          else if (m_act == 3) m_out = !m_out;
        end
        m_cnt = (clra ? ah : ph) ? 0 : nx;
        m_fp = ph && !(m_mode == 0 && m_clr);
        m_fa = ah;
      end
      if (bus_wr_en) begin
        case (bus_addr)
          2'd0: begin
            m_run = bus_wdata[0]; m_pause = bus_wdata[1];
            m_csel = int'(bus_wdata[4:2]); m_P = int'(bus_wdata[7:5]);
          end
          2'd1: begin
            m_mode = int'(bus_wdata[1:0]); m_act = int'(bus_wdata[3:2]);
            m_init = bus_wdata[4]; m_inv = bus_wdata[5]; m_swap = bus_wdata[6]; m_clr = bus_wdata[7];
          end
          2'd2: m_lo = int'(bus_wdata);
          default: m_A = int'(bus_wdata[1:0]) * 256 + m_lo;
        endcase
      end
      s3 = s2; s2 = s1; s1 = ext_clk_i;
      m_pre = (m_pre + 1) % 4;
    end
  end

  function automatic bit exp_pin();
    int duty;
    bit on;
    duty = m_swap ? m_P * 128 : m_A;
    on = (m_cnt < duty);
    if (m_mode == 0) return (m_run ? m_out : m_init) ^ m_inv;
    if (m_mode == 2) return (m_run ? (on ? m_init : !m_init) : m_init) ^ m_inv;
    return m_init;
  endfunction

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(int'(count_o) == m_cnt, cur_req, "count", int'(count_o), m_cnt);
      chk(pin_o == exp_pin(), cur_req, "pin", int'(pin_o), int'(exp_pin()));
      chk(p_irq_o == m_fp, cur_req, "p_irq", int'(p_irq_o), int'(m_fp));
      chk(a_irq_o == m_fa, cur_req, "a_irq", int'(a_irq_o), int'(m_fa));
    end
  end

  // free-running enable and external pin patterns
  initial begin
    int gc;
    gc = 0;
    forever begin
      @(negedge clk);
      gc++;
      fh16_en_i = (gc % 16 == 3);
      fh64_en_i = (gc % 64 == 7);
      fsub_en_i = (gc % 37 == 0);
      ext_clk_i = ((gc / 5) % 2) == 1;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  function automatic logic [7:0] c0(bit run, bit pause, int csel, int per);
    return {3'(per), 3'(csel), pause, run};
  endfunction

  function automatic logic [7:0] c1(bit clr, bit swap, bit inv, bit init, int act, int mode);
    return {clr, swap, inv, init, 2'(act), 2'(mode)};
  endfunction

  task automatic set_a(int v);
    wr(2'd2, 8'(v));
    wr(2'd3, 8'(v >> 8));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int np;
    bit seen_big;
    repeat (4) @(negedge clk);
    // R1: values held during reset
    chk(count_o == 0, "R1", "count in reset", int'(count_o), 0);
    chk(pin_o == 0, "R1", "pin in reset", int'(pin_o), 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    idle(3);
    chk(count_o == 0 && !p_irq_o && !a_irq_o, "R1", "idle after reset", int'(count_o), 0);

    // R10: low byte alone is held, commit on high byte
    cur_req = "R10";
    wr(2'd1, c1(1, 0, 0, 0, 0, 0));
    wr(2'd2, 8'h20);
    wr(2'd0, c0(1, 0, 1, 0));
    idle(60);
    chk(count_o > 10'h20, "R10", "A not committed yet", int'(count_o), 33);
    wr(2'd3, 8'h00);
    idle(1100);
    wr(2'd0, c0(0, 0, 1, 0));

    // R4: period clear from P, and P = 0 wrap
    cur_req = "R4";
    wr(2'd1, c1(0, 0, 0, 0, 0, 3));
    wr(2'd0, c0(1, 0, 1, 1));
    np = 0;
    repeat (400) begin
      @(negedge clk);
      if (p_irq_o) begin
        np++;
        chk(count_o == 0, "R4", "count on period event", int'(count_o), 0);
      end
    end
    chk(np == 3, "R4", "period events in 400 clocks", np, 3);
    wr(2'd0, c0(1, 0, 1, 0));
    idle(1100);
    wr(2'd0, c0(0, 0, 1, 0));

    // R5: clear on A, and A = 0 never matches
    cur_req = "R5";
    wr(2'd1, c1(1, 0, 0, 0, 0, 3));
    set_a(10'h0C5);
    wr(2'd0, c0(1, 0, 1, 2));
    idle(500);
    set_a(0);
    seen_big = 0;
    repeat (1100) begin
      @(negedge clk);
      if (count_o == 10'h3FF) seen_big = 1;
    end
    chk(seen_big, "R5", "A=0 reaches 1023", int'(seen_big), 1);
    wr(2'd0, c0(0, 0, 1, 0));

    // R6: no period events in compare mode with clear-select 1
    cur_req = "R6";
    wr(2'd1, c1(1, 0, 0, 0, 3, 0));
    set_a(10'h150);
    wr(2'd0, c0(1, 0, 1, 1));
    np = 0;
    repeat (800) begin
      @(negedge clk);
      if (p_irq_o) np++;
    end
    chk(np == 0, "R6", "suppressed period events", np, 0);
    wr(2'd0, c0(0, 0, 1, 0));

    // R7: each match action
    cur_req = "R7";
    for (int a = 0; a < 4; a++) begin
      wr(2'd1, c1(1, 0, a[0], a[1], a, 0));
      set_a(10'h040);
      wr(2'd0, c0(1, 0, 1, 0));
      idle(300);
      wr(2'd0, c0(0, 0, 1, 0));
      idle(3);
    end

    // R8: PWM with both swap settings
    cur_req = "R8";
    set_a(10'h060);
    wr(2'd1, c1(0, 0, 0, 1, 0, 2));
    wr(2'd0, c0(1, 0, 1, 2));
    idle(700);
    wr(2'd0, c0(0, 0, 1, 0));
    set_a(10'h090);
    wr(2'd1, c1(0, 1, 0, 0, 0, 2));
    wr(2'd0, c0(1, 0, 1, 1));
    idle(700);
    // R11: change control word 1 while running
    cur_req = "R11";
    wr(2'd1, c1(1, 1, 1, 0, 0, 2));
    idle(400);
    wr(2'd0, c0(0, 0, 1, 0));

    // R9: levels, inversion, timer and reserved modes
    cur_req = "R9";
    wr(2'd1, c1(0, 0, 1, 1, 3, 3));
    wr(2'd0, c0(1, 0, 1, 0));
    idle(200);
    chk(pin_o == 1, "R9", "timer mode pin", int'(pin_o), 1);
    wr(2'd1, c1(0, 0, 1, 0, 3, 1));
    idle(200);
    wr(2'd0, c0(0, 0, 1, 0));
    wr(2'd1, c1(0, 0, 1, 1, 0, 0));
    idle(5);
    chk(pin_o == 0, "R9", "stopped inverted pin", int'(pin_o), 0);

    // R2: every tick source
    cur_req = "R2";
    wr(2'd1, c1(0, 0, 0, 0, 0, 3));
    for (int s = 0; s < 8; s++) begin
      if (s == 1) continue;
      wr(2'd0, c0(1, 0, s, 0));
      idle(400);
      wr(2'd0, c0(0, 0, s, 0));
    end

    // R3: pause and stop
    cur_req = "R3";
    wr(2'd0, c0(1, 0, 1, 0));
    idle(40);
    wr(2'd0, c0(1, 1, 1, 0));
    idle(50);
    wr(2'd0, c0(1, 0, 1, 0));
    idle(30);
    wr(2'd0, c0(0, 0, 1, 0));
    idle(5);
    chk(count_o == 0, "R3", "count after stop", int'(count_o), 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule